// File: doc/BRIEF.md
# Two-Level Local Branch Direction and Target Predictor

This block gives the fetch stage a guess at the next fetch address for a branch. Each branch address has its own short record of recent outcomes. That record selects one of a small set of shared 2-bit saturating counters, and the counter gives the direction. A separate target table keeps the full address of each taken branch and its destination.

A lookup is purely combinational on the lookup address. It reports a usable target only when the target table holds that exact branch and the selected counter says taken. Training arrives from branches as they retire in program order, carrying the resolved direction and target. The update takes effect at the clock edge, so a lookup in the same cycle still sees the older state.

Top module: `bpred_local`

## Requirements
- R1: After reset every target-table entry is empty, every history is 000 and every counter holds 01, so no lookup reports a hit, a taken direction or a valid prediction.
- R2: Lookup and update select the history entry and the target-table entry with address bits [5:2]. Addresses that differ only above bit 5 share a history entry.
- R3: Each counter is 2 bits wide and saturates at 00 and at 11. A counter predicts taken when its bit 1 is set.
- R4: An update shifts its outcome into the branch's history as the new bit 0, with taken = 1. The older bits move up one place and the oldest bit is dropped.
- R5: An update moves the counter selected by the branch's history as it stood before that same update: up when taken, down when not taken.
- R6: A target-table hit requires a written entry whose stored branch address equals the whole lookup address.
- R7: A taken update writes the branch address and target into the entry. A not-taken update leaves the target table unchanged.
- R8: The prediction is valid exactly when the lookup hits and the selected counter predicts taken. The predicted target is the stored target of the selected entry.
- R9: A lookup in the same cycle as an update of the same entry returns the values from before that update.
- R10: While the update enable is low, the update address, direction and target have no effect on any later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| pred_valid | output | 1 | Predicted target may be used by fetch |
| pred_taken | output | 1 | Selected counter predicts taken |
| btb_hit | output | 1 | Target table holds this exact branch |
| lk_target | output | PC_W | Stored target of the selected entry |
| up_en | input | 1 | A retiring branch trains the predictor this cycle |
| up_pc | input | PC_W | Address of the retiring branch |
| up_taken | input | 1 | Resolved direction of the retiring branch |
| up_target | input | PC_W | Resolved target of the retiring branch |

## Verification
The bound checker watches four things on every cycle: the empty state right after reset, the hit and the new target one cycle after a taken update, an unchanged target entry after a not-taken update, and unchanged lookup results while training is idle. Counter saturation at both ends, the use of the history from before the update, the history shift order, aliasing through bits [5:2] and the same-cycle read ordering all depend on the sequence of updates. Only the bench scenarios and its per-cycle reference model can show them.

// File: rtl/bpred_local.sv
module bpred_local #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            btb_hit,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_en,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target
);
  localparam int ENT = 1 << IDX_W;
  localparam int PAT = 1 << HIST_W;
  localparam int LSB = 2;

  logic [HIST_W-1:0] hist_q [ENT];
  logic [1:0]        cnt_q  [PAT];
  logic [ENT-1:0]    bv_q;
  logic [PC_W-1:0]   tag_q  [ENT];
  logic [PC_W-1:0]   tgt_q  [ENT];

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] lk_hist, up_hist, hist_nxt;
  logic [HIST_W:0]   hist_cat;
  logic [1:0]        up_cnt, cnt_nxt;

  assign lk_idx     = lk_pc[LSB +: IDX_W];
  assign lk_hist    = hist_q[lk_idx];
  assign pred_taken = cnt_q[lk_hist][1];
  assign btb_hit    = bv_q[lk_idx] && (tag_q[lk_idx] == lk_pc);
  assign pred_valid = btb_hit && pred_taken;
  assign lk_target  = tgt_q[lk_idx];

  assign up_idx   = up_pc[LSB +: IDX_W];
  assign up_hist  = hist_q[up_idx];
  assign up_cnt   = cnt_q[up_hist];
  assign hist_cat = {up_hist, up_taken};
  assign hist_nxt = hist_cat[HIST_W-1:0];

  always_comb begin
    if (up_taken) cnt_nxt = (up_cnt == 2'b11) ? 2'b11 : up_cnt + 2'd1;
    else          cnt_nxt = (up_cnt == 2'b00) ? 2'b00 : up_cnt - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) hist_q[i] <= '0;
      for (int j = 0; j < PAT; j++) cnt_q[j] <= 2'b01;
      bv_q <= '0;
    end else if (up_en) begin
      hist_q[up_idx] <= hist_nxt;
      cnt_q[up_hist] <= cnt_nxt;
      if (up_taken) bv_q[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && up_en && up_taken) begin
      tag_q[up_idx] <= up_pc;
      tgt_q[up_idx] <= up_target;
    end
  end
endmodule

// File: rtl/bpred_local_sva.sv
module bpred_local_sva #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            pred_valid,
  input logic            pred_taken,
  input logic            btb_hit,
  input logic [PC_W-1:0] lk_target,
  input logic            up_en,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic [PC_W-1:0] up_target
);
  assert_reset_empty_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!btb_hit && !pred_valid && !pred_taken));

  assert_taken_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(up_en && up_taken) && lk_pc == $past(up_pc))
      |-> (btb_hit && lk_target == $past(up_target)));

  assert_not_taken_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(up_en && !up_taken) && $stable(lk_pc))
      |-> ($stable(lk_target) && $stable(btb_hit)));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(up_en) && $stable(lk_pc))
      |-> ($stable(lk_target) && $stable(pred_taken) && $stable(btb_hit) && $stable(pred_valid)));
endmodule

bind bpred_local bpred_local_sva #(.PC_W(PC_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .btb_hit(btb_hit), .lk_target(lk_target),
  .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
);

// File: tb/tb_bpred_local.sv
module tb_bpred_local;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic        pred_valid, pred_taken, btb_hit;
  logic [31:0] lk_target;
  logic        up_en = 0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 0;
  logic [31:0] up_target = '0;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  bpred_local dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .btb_hit(btb_hit), .lk_target(lk_target),
    .up_en(up_en), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
  );

  // behavioural reference model
  int          m_hist [16];
  int          m_cnt  [8];
  bit          m_v    [16];
  logic [31:0] m_tag  [16];
  logic [31:0] m_tgt  [16];

  function automatic int ix(logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_hist[i] = 0; m_v[i] = 0; end
      for (int i = 0; i < 8; i++) m_cnt[i] = 1;
    end else if (up_en) begin
      int k, h;
      k = ix(up_pc);
      h = m_hist[k];
      if (up_taken) m_cnt[h] = (m_cnt[h] == 3) ? 3 : m_cnt[h] + 1;
      else          m_cnt[h] = (m_cnt[h] == 0) ? 0 : m_cnt[h] - 1;
      m_hist[k] = ((h * 2) + (up_taken ? 1 : 0)) % 8;
      if (up_taken) begin m_v[k] = 1; m_tag[k] = up_pc; m_tgt[k] = up_target; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int k;
      bit et, eh;
      k  = ix(lk_pc);
      et = m_cnt[m_hist[k]] >= 2;
      eh = m_v[k] && (m_tag[k] == lk_pc);
      tests++;
      if (pred_taken !== et || btb_hit !== eh || pred_valid !== (et && eh) ||
          (eh && lk_target !== m_tgt[k])) begin
        fails++;
        $display("FAIL R8 model pc=%h: got t=%b h=%b v=%b tgt=%h exp t=%b h=%b v=%b tgt=%h",
                 lk_pc, pred_taken, btb_hit, pred_valid, lk_target, et, eh, et && eh, m_tgt[k]);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic upd(logic [31:0] pc, bit tk, logic [31:0] tg);
    @(negedge clk); #1;
    up_en = 1; up_pc = pc; up_taken = tk; up_target = tg;
    @(negedge clk); #1;
    up_en = 0;
  endtask

  task automatic look(logic [31:0] pc);
    @(negedge clk); #1;
    lk_pc = pc;
    #1;
  endtask

  localparam logic [31:0] PA = 32'h0000_1004, PB = 32'h0000_1008;
  localparam logic [31:0] PC3 = 32'h0000_100C, PD = 32'h0000_1044;
  localparam logic [31:0] T1 = 32'h0000_2000, T2 = 32'h0000_3000;
  localparam logic [31:0] TC = 32'h0000_4000, TC2 = 32'h0000_5000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    look(PB);
    chk("R1 hit", btb_hit, 0);
    chk("R1 taken", pred_taken, 0);
    chk("R1 valid", pred_valid, 0);

    upd(PA, 1, T1);
    look(PA);
    chk("R5 A taken (hist 001 -> ctr01)", pred_taken, 0);
    chk("R6 A hit", btb_hit, 1);
    chk("R8 A valid", pred_valid, 0);
    chk("R7 A target", lk_target, T1);
    look(PB);
    chk("R5 B taken (ctr0 = 10)", pred_taken, 1);
    chk("R8 B valid without hit", pred_valid, 0);

    upd(PA, 1, T1); upd(PA, 1, T1); upd(PA, 1, T1);
    look(PA);
    chk("R4 A taken after 111 history", pred_taken, 1);
    chk("R8 A valid", pred_valid, 1);
    chk("R8 A target", lk_target, T1);

    upd(PA, 1, T1); upd(PA, 1, T1);
    look(PD);
    chk("R2 alias shares history", pred_taken, 1);
    chk("R6 alias no hit", btb_hit, 0);
    chk("R6 alias not valid", pred_valid, 0);
    look(PA | 32'h2);
    chk("R6 low-bit mismatch", btb_hit, 0);

    upd(PA, 0, T2);
    look(PA);
    chk("R4 A hist 110 -> ctr01", pred_taken, 0);
    chk("R7 not-taken keeps target", lk_target, T1);
    chk("R7 not-taken keeps hit", btb_hit, 1);

    @(negedge clk); #1;
    up_en = 0; up_pc = PA; up_taken = 1; up_target = T2;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 idle target", lk_target, T1);
    chk("R10 idle taken", pred_taken, 0);

    upd(PC3, 0, TC); upd(PC3, 0, TC); upd(PC3, 0, TC);
    upd(PC3, 1, TC);
    look(PB);
    chk("R3 floor saturation", pred_taken, 0);
    look(PC3);
    chk("R3 ctr1 = 10 taken", pred_taken, 1);
    chk("R7 C target", lk_target, TC);

    @(negedge clk); #1;
    up_en = 1; up_pc = PC3; up_taken = 1; up_target = TC2;
    #1;
    chk("R9 same-cycle target", lk_target, TC);
    chk("R9 same-cycle taken", pred_taken, 1);
    @(negedge clk); #1;
    up_en = 0;
    #1;
    chk("R9 after edge target", lk_target, TC2);
    chk("R4 C hist 011 -> ctr3 taken", pred_taken, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule